// File: doc/BRIEF.md
# Pattern-Table Transmit Stream Source

This block feeds the transmit side of a serial transceiver with a known, endlessly repeating test stream. The stream comes from a constant table built at elaboration time from parameters. Most slots hold an incrementing count. One slot holds a comma word that marks the start of a packet. An optional run of slots holds a channel-bonding sequence. Every slot also stores one flag bit per data byte that marks that byte as a control character. The flags leave the block together with the data word.

One table slot is read per enabled cycle of the user clock. The read address advances by one and returns to zero after the last slot, so the pattern repeats for as long as the enable stays high. When the enable is low the address and the outputs hold their values. A synchronous reset clears the address and drives the outputs to zero. A receive-side checker that holds the same table can therefore lock onto the comma and compare every later word against it.

Top module: `pattern_frame_gen`

## Requirements
- R1: A cycle with `rst` high makes `tx_word` and `tx_kflag` zero and sets the read address to slot 0. The first enabled cycle after that presents slot 0.
- R2: A cycle with `en` low and `rst` low leaves `tx_word`, `tx_kflag` and the read address unchanged. The next enabled cycle presents the slot that would have come next.
- R3: A count slot `i` outputs `COUNT_BASE + i` (modulo 2^DATA_W) with `tx_kflag` all zero. Every slot that is neither comma nor bonding is a count slot.
- R4: With `COMMA_EN` = 1, slot `COMMA_POS` outputs `COMMA_WORD` with `COMMA_FLAGS`. The defaults put it at slot 0 as 16'h50BC with flags 2'b01, where flag bit j marks byte j (bit 0 is bits 7:0).
- R5: With `BOND_EN` = 1, slot `BOND_POS + k` for k < `BOND_LEN` outputs `BOND_WORD + k*BOND_STEP` with `BOND_FLAGS`. The defaults are slots 32 and 33 carrying 16'h3C7C and 16'h3D7C, each with flags 2'b01. The comma takes priority where the two overlap.
- R6: Each enabled cycle advances the read address by one. After slot `DEPTH-1` it returns to slot 0, so the output sequence repeats with period `DEPTH` (default 64).
- R7: With `COMMA_EN` = 0 and `BOND_EN` = 0, every slot is a count slot, including slot `COMMA_POS`.
- R8: Reset wins over enable. A cycle with both `rst` and `en` high gives zero outputs, and the next enabled cycle presents slot 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | User clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Clock enable: read and advance one slot |
| tx_word | output | DATA_W | Data word toward the transmitter |
| tx_kflag | output | DATA_W/8 | Per-byte control-character flags |

## Verification
Two events can land in the same cycle.

The first is the wrap from the last slot into the comma slot at index 0. The bench walks more than two full periods without a break and compares every word and flag pair against a table it computes itself from the requirements. A wrong wrap shows up as an unexpected word at the period boundary. It also shows up as a missing comma flag.

The second is a reset that arrives together with the enable, in the middle of the stream. The bench raises both for one cycle. It then expects zero outputs and, on the next enabled cycle, the comma slot, not the slot that would have followed.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        SLOT_COUNT = 2'd0,
        SLOT_COMMA = 2'd1,
        SLOT_BOND  = 2'd2
    } slot_kind_e;

    // Decide what a table slot carries; the comma wins over the bonding run.
    function automatic slot_kind_e classify(
        input int idx,
        input bit comma_en,
        input int comma_pos,
        input bit bond_en,
        input int bond_pos,
        input int bond_len
    );
        if (comma_en && idx == comma_pos)
            return SLOT_COMMA;
        if (bond_en && idx >= bond_pos && idx < bond_pos + bond_len)
            return SLOT_BOND;
        return SLOT_COUNT;
    endfunction

endpackage

// File: rtl/pfg_rom.sv
module pfg_rom #(
    parameter int                 DATA_W      = 16,
    parameter int                 DEPTH       = 64,
    parameter logic [DATA_W-1:0]  COUNT_BASE  = '0,
    parameter bit                 COMMA_EN    = 1'b1,
    parameter int                 COMMA_POS   = 0,
    parameter logic [DATA_W-1:0]  COMMA_WORD  = 16'h50BC,
    parameter logic [DATA_W/8-1:0] COMMA_FLAGS = 2'b01,
    parameter bit                 BOND_EN     = 1'b1,
    parameter int                 BOND_POS    = 32,
    parameter int                 BOND_LEN    = 2,
    parameter logic [DATA_W-1:0]  BOND_WORD   = 16'h3C7C,
    parameter logic [DATA_W-1:0]  BOND_STEP   = 16'h0100,
    parameter logic [DATA_W/8-1:0] BOND_FLAGS  = 2'b01,
    localparam int                CTRL_W      = DATA_W / 8,
    localparam int                ADDR_W      = $clog2(DEPTH)
) (
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_word,
    output logic [CTRL_W-1:0] rd_flags
);
    import pfg_pkg::*;

    localparam int ENTRY_W = DATA_W + CTRL_W;

    logic [ENTRY_W-1:0] table_w [DEPTH];

    // Each slot is a constant derived from the parameters.
    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        localparam slot_kind_e KIND =
            classify(i, COMMA_EN, COMMA_POS, BOND_EN, BOND_POS, BOND_LEN);
        if (KIND == SLOT_COMMA) begin : g_comma
            assign table_w[i] = {COMMA_FLAGS, COMMA_WORD};
        end else if (KIND == SLOT_BOND) begin : g_bond
            localparam logic [DATA_W-1:0] STEP_IDX = DATA_W'(i - BOND_POS);
            localparam logic [DATA_W-1:0] BW = BOND_WORD + STEP_IDX * BOND_STEP;
            assign table_w[i] = {BOND_FLAGS, BW};
        end else begin : g_count
            localparam logic [DATA_W-1:0] CW = COUNT_BASE + DATA_W'(i);
            assign table_w[i] = {{CTRL_W{1'b0}}, CW};
        end
    end

    assign {rd_flags, rd_word} = table_w[rd_addr];

endmodule

// File: rtl/pfg_addr_seq.sv
module pfg_addr_seq #(
    parameter  int DEPTH  = 64,
    localparam int ADDR_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    output logic [ADDR_W-1:0] addr
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    typedef struct packed {
        logic [ADDR_W-1:0] addr;
    } seq_t;

    seq_t seq_d, seq_q;

    always_comb begin
        seq_d = seq_q;
        if (rst) begin
            seq_d.addr = '0;
        end else if (en) begin
            if (seq_q.addr == LAST)
                seq_d.addr = '0;
            else
                seq_d.addr = seq_q.addr + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        seq_q <= seq_d;
    end

    assign addr = seq_q.addr;

endmodule

// File: rtl/pfg_out_stage.sv
module pfg_out_stage #(
    parameter  int DATA_W = 16,
    localparam int CTRL_W = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [DATA_W-1:0] slot_word,
    input  logic [CTRL_W-1:0] slot_flags,
    output logic [DATA_W-1:0] word,
    output logic [CTRL_W-1:0] flags
);
    typedef struct packed {
        logic [DATA_W-1:0] word;
        logic [CTRL_W-1:0] flags;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d = out_q;
        if (rst) begin
            out_d = '0;
        end else if (en) begin
            out_d.word  = slot_word;
            out_d.flags = slot_flags;
        end
    end

    always_ff @(posedge clk) begin
        out_q <= out_d;
    end

    assign word  = out_q.word;
    assign flags = out_q.flags;

endmodule

// File: rtl/pattern_frame_gen.sv
module pattern_frame_gen #(
    parameter int                  DATA_W      = 16,
    parameter int                  DEPTH       = 64,
    parameter logic [DATA_W-1:0]   COUNT_BASE  = '0,
    parameter bit                  COMMA_EN    = 1'b1,
    parameter int                  COMMA_POS   = 0,
    parameter logic [DATA_W-1:0]   COMMA_WORD  = 16'h50BC,
    parameter logic [DATA_W/8-1:0] COMMA_FLAGS = 2'b01,
    parameter bit                  BOND_EN     = 1'b1,
    parameter int                  BOND_POS    = 32,
    parameter int                  BOND_LEN    = 2,
    parameter logic [DATA_W-1:0]   BOND_WORD   = 16'h3C7C,
    parameter logic [DATA_W-1:0]   BOND_STEP   = 16'h0100,
    parameter logic [DATA_W/8-1:0] BOND_FLAGS  = 2'b01
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    output logic [DATA_W-1:0]   tx_word,
    output logic [DATA_W/8-1:0] tx_kflag
);
    localparam int CTRL_W = DATA_W / 8;
    localparam int ADDR_W = $clog2(DEPTH);

    logic [ADDR_W-1:0] rd_addr;
    logic [DATA_W-1:0] slot_word;
    logic [CTRL_W-1:0] slot_flags;

    pfg_addr_seq #(
        .DEPTH (DEPTH)
    ) u_seq (
        .clk  (clk),
        .rst  (rst),
        .en   (en),
        .addr (rd_addr)
    );

    pfg_rom #(
        .DATA_W      (DATA_W),
        .DEPTH       (DEPTH),
        .COUNT_BASE  (COUNT_BASE),
        .COMMA_EN    (COMMA_EN),
        .COMMA_POS   (COMMA_POS),
        .COMMA_WORD  (COMMA_WORD),
        .COMMA_FLAGS (COMMA_FLAGS),
        .BOND_EN     (BOND_EN),
        .BOND_POS    (BOND_POS),
        .BOND_LEN    (BOND_LEN),
        .BOND_WORD   (BOND_WORD),
        .BOND_STEP   (BOND_STEP),
        .BOND_FLAGS  (BOND_FLAGS)
    ) u_rom (
        .rd_addr  (rd_addr),
        .rd_word  (slot_word),
        .rd_flags (slot_flags)
    );

    pfg_out_stage #(
        .DATA_W (DATA_W)
    ) u_out (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .slot_word  (slot_word),
        .slot_flags (slot_flags),
        .word       (tx_word),
        .flags      (tx_kflag)
    );

endmodule

// File: rtl/pfg_chk.sv
module pfg_chk #(
    parameter  int                  DATA_W      = 16,
    parameter  int                  DEPTH       = 64,
    parameter  bit                  COMMA_EN    = 1'b1,
    parameter  int                  COMMA_POS   = 0,
    parameter  logic [DATA_W-1:0]   COMMA_WORD  = 16'h50BC,
    parameter  logic [DATA_W/8-1:0] COMMA_FLAGS = 2'b01,
    localparam int                  CTRL_W      = DATA_W / 8,
    localparam int                  ADDR_W      = $clog2(DEPTH)
) (
    input logic              clk,
    input logic              rst,
    input logic              en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] word,
    input logic [CTRL_W-1:0] kflag
);
    localparam logic [ADDR_W-1:0] LAST = ADDR_W'(DEPTH - 1);

    logic rst_seen_q;

    always_ff @(posedge clk) begin
        rst_seen_q <= rst;
    end

    // R1
    always_ff @(posedge clk) begin
        if (rst_seen_q) begin
            rst_clear_chk: assert (word == '0 && kflag == '0 && addr == '0)
                else $error("outputs not cleared after reset");
        end
    end

    // R2
    hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(word) && $stable(kflag) && $stable(addr)));

    // R6
    wrap_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (en && addr == LAST) |=> addr == '0);

    // R6
    addr_step_chk: assert property (@(posedge clk) disable iff (rst)
        (en && addr != LAST) |=> addr == $past(addr) + 1'b1);

    // R4
    comma_slot_chk: assert property (@(posedge clk) disable iff (rst)
        (COMMA_EN && en && addr == ADDR_W'(COMMA_POS)) |=>
            (word == COMMA_WORD && kflag == COMMA_FLAGS));

endmodule

bind pattern_frame_gen pfg_chk #(
    .DATA_W      (DATA_W),
    .DEPTH       (DEPTH),
    .COMMA_EN    (COMMA_EN),
    .COMMA_POS   (COMMA_POS),
    .COMMA_WORD  (COMMA_WORD),
    .COMMA_FLAGS (COMMA_FLAGS)
) u_chk (
    .clk   (clk),
    .rst   (rst),
    .en    (en),
    .addr  (rd_addr),
    .word  (tx_word),
    .kflag (tx_kflag)
);

// File: tb/test_pattern_frame_gen.sv
`timescale 1ns/1ps
module test_pattern_frame_gen;

    localparam int DEPTH   = 64;
    localparam int P_DEPTH = 8;
    localparam logic [15:0] P_BASE = 16'h1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en  = 1'b0;
    logic [15:0] tx_word,  p_word;
    logic [1:0]  tx_kflag, p_kflag;

    int total = 0;
    int bad   = 0;
    int idx   = 0;   // slot the next enabled cycle should present
    int pidx  = 0;

    always #2.5 clk = ~clk;   // 200 MHz

    pattern_frame_gen i_pattern_frame_gen (
        .clk(clk), .rst(rst), .en(en), .tx_word(tx_word), .tx_kflag(tx_kflag)
    );

    pattern_frame_gen #(
        .DEPTH(P_DEPTH), .COUNT_BASE(P_BASE), .COMMA_EN(1'b0), .BOND_EN(1'b0)
    ) i_pattern_frame_gen_plain (
        .clk(clk), .rst(rst), .en(en), .tx_word(p_word), .tx_kflag(p_kflag)
    );

    // Expected slot contents for the default instance, from R3, R4, R5.
    function automatic logic [17:0] exp_slot(input int i);
        if (i == 0)  return {2'b01, 16'h50BC};
        if (i == 32) return {2'b01, 16'h3C7C};
        if (i == 33) return {2'b01, 16'h3D7C};
        return {2'b00, 16'(i)};
    endfunction

    task automatic check(input string req, input logic [15:0] aw, input logic [1:0] af,
                         input logic [15:0] ew, input logic [1:0] ef);
        total++;
        if (aw !== ew || af !== ef) begin
            bad++;
            $display("FAIL %s: got %h/%b expected %h/%b", req, aw, af, ew, ef);
        end
    endtask

    // One cycle: drive at a falling edge, results visible at the next one.
    task automatic cycle(input logic r, input logic e);
        rst = r;
        en  = e;
        @(negedge clk);
        if (r) begin
            idx  = 0;
            pidx = 0;
        end else if (e) begin
            idx  = (idx + 1) % DEPTH;
            pidx = (pidx + 1) % P_DEPTH;
        end
    endtask

    task automatic check_main(input string req);
        logic [17:0] e;
        e = exp_slot((idx + DEPTH - 1) % DEPTH);
        check(req, tx_word, tx_kflag, e[15:0], e[17:16]);
    endtask

    task automatic t_reset;
        cycle(1'b1, 1'b0);
        check("R1 reset outputs", tx_word, tx_kflag, 16'h0000, 2'b00);
        check("R1 reset outputs plain", p_word, p_kflag, 16'h0000, 2'b00);
        cycle(1'b0, 1'b1);
        check("R1 first slot after reset", tx_word, tx_kflag, 16'h50BC, 2'b01);
    endtask

    // Runs past two wraps; covers count, comma, bonding and the plain variant.
    task automatic t_walk;
        for (int n = 0; n < 2 * DEPTH + 5; n++) begin
            cycle(1'b0, 1'b1);
            check_main("R3/R4/R5/R6 walk");
            check("R7 plain slot", p_word, p_kflag,
                  P_BASE + 16'((pidx + P_DEPTH - 1) % P_DEPTH), 2'b00);
        end
    endtask

    task automatic t_hold;
        logic [15:0] w;
        logic [1:0]  f;
        w = tx_word;
        f = tx_kflag;
        for (int n = 0; n < 5; n++) begin
            cycle(1'b0, 1'b0);
            check("R2 hold while disabled", tx_word, tx_kflag, w, f);
        end
        cycle(1'b0, 1'b1);
        check_main("R2 resume after hold");
    endtask

    task automatic t_wrap_into_comma;
        while (idx != DEPTH - 1) cycle(1'b0, 1'b1);
        cycle(1'b0, 1'b1);
        check("R6 last slot", tx_word, tx_kflag, 16'd63, 2'b00);
        cycle(1'b0, 1'b1);
        check("R6 R4 wrap into comma", tx_word, tx_kflag, 16'h50BC, 2'b01);
    endtask

    task automatic t_reset_collide;
        for (int n = 0; n < 7; n++) cycle(1'b0, 1'b1);
        cycle(1'b1, 1'b1);
        check("R8 reset beats enable", tx_word, tx_kflag, 16'h0000, 2'b00);
        cycle(1'b0, 1'b1);
        check("R8 slot 0 after collision", tx_word, tx_kflag, 16'h50BC, 2'b01);
        check("R8 plain slot 0 after collision", p_word, p_kflag, P_BASE, 2'b00);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_walk();
        t_hold();
        t_wrap_into_comma();
        t_reset_collide();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule